// File: doc/BRIEF.md
# Signed Integer Divider

This block is a multi-cycle divider for the execute stage of a processor. It takes a signed dividend and a signed divisor, both in two's complement, and returns their quotient rounded toward zero. A single mode input chooses the width for each operation. When it is 0, the unit uses only the low 32 bits of each operand and returns a 32-bit result, zero-extended onto the 64-bit output. When it is 1, the unit uses all 64 bits.

Control is a start/busy/done handshake. A start pulse while the unit is idle captures both operands and the mode. The unit then produces one quotient bit per clock, working on the operand magnitudes. A final cycle applies the sign. `done` pulses high for one cycle and the quotient appears on the output at the same time. The output then holds that value until the next operation completes. A zero divisor is not an error: the unit returns zero one cycle after start and never enters the iterative phase. The unit has no remainder, flag or exception outputs. An overflowing quotient wraps to the selected width.

The control FSM has three states. `ST_IDLE` is the waiting state. `ST_RUN` is the iterative phase, one restoring step per cycle, with a down-counter loaded with the width minus one. `ST_SIGN` is the single cycle that negates and masks the result. Its transitions are as follows:
- IDLE→RUN is taken on an accepted start with a non-zero divisor.
- IDLE→IDLE is taken on an accepted start with a zero divisor, which finishes at once.
- RUN→RUN is taken while the counter is non-zero.
- RUN→SIGN is taken when the counter reaches zero.
- SIGN→IDLE is always taken.

Top module: `sgn_div_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `done` and `quotient` are all cleared to zero from that edge on.
- R2: A `start` sampled high while `busy` is low captures `dividend`, `divisor` and `wide`. If the divisor at the selected width is non-zero, `busy` is high from the next cycle until the result is delivered.
- R3: The quotient equals dividend divided by divisor rounded toward zero, both read as two's-complement values. For example, -7/2 gives -3, 7/-2 gives -3 and -7/-2 gives 3.
- R4: With `wide` = 0, only bits [31:0] of each operand affect the result, and `quotient[63:32]` is zero whenever `done` is high.
- R5: With `wide` = 1, all 64 operand bits are used and the full 64-bit quotient is returned.
- R6: A divisor that is zero at the selected width gives `done` high in the cycle after the start edge, with `quotient` zero and `busy` staying low. No other output signals the event.
- R7: The most negative value of the selected width divided by -1 returns that same most negative value, because the result keeps only the low bits of the selected width.
- R8: For a non-zero divisor, `done` rises exactly W+1 cycles after the start edge, where W is 32 or 64 by the captured mode. `done` stays high for a single cycle, and `busy` is low whenever `done` is high.
- R9: Changes on `dividend`, `divisor` and `wide` while busy, and any `start` pulse while busy, do not alter the result or the completion time of the operation in progress.
- R10: `quotient` changes only in a cycle where `done` is high, and it holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted only while idle |
| wide | input | 1 | Width select: 0 = 32-bit, 1 = 64-bit |
| dividend | input | 64 | Signed dividend |
| divisor | input | 64 | Signed divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: quotient is valid |
| quotient | output | 64 | Signed quotient, held until the next completion |

## Verification
A wrong iteration count or a counter loaded for the wrong width shows up as a `done` pulse that arrives early or late. The bench measures this per operation, so it is caught at the end of the first affected division. A wrong sign flag or wrong operand magnitude shows up as a wrong quotient on the first operands of mixed sign or of extreme value. The directed cases include -7/2, the most-negative/-1 pair and garbage in the upper operand bits in narrow mode, so these errors appear within the first dozen operations. A capture register that follows the inputs instead of holding them shows up as a wrong result on the disturbed operations, where the operands and the mode are changed and `start` is pulsed mid-run.

// File: rtl/sgn_div_pkg.sv
package sgn_div_pkg;

    // Control states of the divider sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SIGN = 2'd2
    } div_state_e;

endpackage

// File: rtl/sgn_div_prep.sv
// Operand conditioning: width-select sign extension, magnitude extraction,
// alignment of a narrow dividend into the top of the shift register.
module sgn_div_prep #(
    parameter int XLEN = 64,
    parameter int NLEN = 32
) (
    input  logic [XLEN-1:0] num_raw,
    input  logic [XLEN-1:0] den_raw,
    input  logic            wide,
    output logic [XLEN-1:0] num_mag,
    output logic [XLEN-1:0] den_mag,
    output logic            neg_res,
    output logic            den_zero
);
    localparam int PAD = XLEN - NLEN;

    logic [XLEN-1:0] num_ext;
    logic [XLEN-1:0] den_ext;
    logic [XLEN-1:0] num_abs;
    logic            num_neg;
    logic            den_neg;

    always_comb begin
        if (wide) begin
            num_ext = num_raw;
            den_ext = den_raw;
        end else begin
            num_ext = {{PAD{num_raw[NLEN-1]}}, num_raw[NLEN-1:0]};
            den_ext = {{PAD{den_raw[NLEN-1]}}, den_raw[NLEN-1:0]};
        end
        num_neg  = num_ext[XLEN-1];
        den_neg  = den_ext[XLEN-1];
        num_abs  = num_neg ? (~num_ext + 1'b1) : num_ext;
        den_mag  = den_neg ? (~den_ext + 1'b1) : den_ext;
        num_mag  = wide ? num_abs : (num_abs << PAD);
        neg_res  = num_neg ^ den_neg;
        den_zero = (den_ext == '0);
    end

endmodule

// File: rtl/sgn_div_step.sv
// One restoring division step: shift in the next dividend bit, trial subtract.
module sgn_div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN:0]   rem_in,
    input  logic [XLEN-1:0] qsh_in,
    input  logic [XLEN-1:0] den,
    output logic [XLEN:0]   rem_out,
    output logic [XLEN-1:0] qsh_out
);
    logic [XLEN:0] trial;
    logic [XLEN:0] diff;
    logic          fits;

    always_comb begin
        trial   = {rem_in[XLEN-1:0], qsh_in[XLEN-1]};
        diff    = trial - {1'b0, den};
        fits    = (trial >= {1'b0, den});
        rem_out = fits ? diff : trial;
        qsh_out = {qsh_in[XLEN-2:0], fits};
    end

endmodule

// File: rtl/sgn_div_fsm.sv
// Sequencer: idle / iterate / sign-fix, with a per-width step counter.
module sgn_div_fsm
    import sgn_div_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NLEN = 32,
    localparam int CW  = $clog2(XLEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic wide,
    input  logic den_zero,
    output logic busy,
    output logic load,
    output logic step_en,
    output logic finish,
    output logic quick
);
    div_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !den_zero) begin
                    state_d = ST_RUN;
                    cnt_d   = wide ? CW'(XLEN - 1) : CW'(NLEN - 1);
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) begin
                    state_d = ST_SIGN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SIGN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        busy    = 1'b0;
        load    = 1'b0;
        step_en = 1'b0;
        finish  = 1'b0;
        quick   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load  = start && !den_zero;
                quick = start && den_zero;
            end
            ST_RUN: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_SIGN: begin
                busy   = 1'b1;
                finish = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/sgn_div_unit.sv
// Signed multi-cycle divider, 32/64-bit selectable, truncating quotient.
module sgn_div_unit #(
    parameter int XLEN = 64,
    parameter int NLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            wide,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] quotient
);
    localparam int PAD = XLEN - NLEN;

    logic [XLEN-1:0] num_mag, den_mag;
    logic            neg_res, den_zero;
    logic            load, step_en, finish, quick;

    logic [XLEN:0]   rem_q, rem_nx;
    logic [XLEN-1:0] qsh_q, qsh_nx;
    logic [XLEN-1:0] den_q;
    logic            neg_q, wide_q;
    logic [XLEN-1:0] quo_q;
    logic            done_q;
    logic [XLEN-1:0] signed_mag, result;

    sgn_div_prep #(.XLEN(XLEN), .NLEN(NLEN)) u_prep (
        .num_raw  (dividend),
        .den_raw  (divisor),
        .wide     (wide),
        .num_mag  (num_mag),
        .den_mag  (den_mag),
        .neg_res  (neg_res),
        .den_zero (den_zero)
    );

    sgn_div_fsm #(.XLEN(XLEN), .NLEN(NLEN)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wide     (wide),
        .den_zero (den_zero),
        .busy     (busy),
        .load     (load),
        .step_en  (step_en),
        .finish   (finish),
        .quick    (quick)
    );

    sgn_div_step #(.XLEN(XLEN)) u_step (
        .rem_in  (rem_q),
        .qsh_in  (qsh_q),
        .den     (den_q),
        .rem_out (rem_nx),
        .qsh_out (qsh_nx)
    );

    // Sign fix and width truncation of the finished magnitude
    always_comb begin
        signed_mag = neg_q ? (~qsh_q + 1'b1) : qsh_q;
        result     = wide_q ? signed_mag : {{PAD{1'b0}}, signed_mag[NLEN-1:0]};
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            qsh_q  <= '0;
            den_q  <= '0;
            neg_q  <= 1'b0;
            wide_q <= 1'b0;
            quo_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                rem_q  <= '0;
                qsh_q  <= num_mag;
                den_q  <= den_mag;
                neg_q  <= neg_res;
                wide_q <= wide;
            end else if (step_en) begin
                rem_q <= rem_nx;
                qsh_q <= qsh_nx;
            end
            if (finish) begin
                quo_q  <= result;
                done_q <= 1'b1;
            end else if (quick) begin
                quo_q  <= '0;
                done_q <= 1'b1;
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

endmodule

// File: rtl/sgn_div_chk.sv
// Port-level protocol checker, bound to the divider.
module sgn_div_chk #(
    parameter int XLEN = 64,
    parameter int NLEN = 32,
    localparam int BW  = $clog2(XLEN + 4)
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            wide,
    input logic [XLEN-1:0] divisor,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] quotient
);
    logic          zero_in;
    logic          mode_q;
    logic [BW-1:0] busy_run;

    assign zero_in = wide ? (divisor == '0) : (divisor[NLEN-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= 1'b0;
            busy_run <= '0;
        end else begin
            if (start && !busy) mode_q <= wide;
            busy_run <= busy ? busy_run + 1'b1 : '0;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BW'(XLEN + 1));

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && zero_in) |=> (done && !busy && quotient == '0));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !zero_in) |=> busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R4
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (quotient[XLEN-1:NLEN] == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(quotient) |-> done);

endmodule

bind sgn_div_unit sgn_div_chk #(.XLEN(XLEN), .NLEN(NLEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wide     (wide),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .quotient (quotient)
);

// File: tb/sgn_div_unit_bench.sv
module sgn_div_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        busy, done;
    logic [63:0] quotient;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sgn_div_unit u_sgn_div_unit (
        .clk(clk), .rst(rst), .start(start), .wide(wide),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_div(input logic [63:0] a, input logic [63:0] b,
                                            input logic w);
        if (!w) begin
            int sa = $signed(a[31:0]);
            int sb = $signed(b[31:0]);
            int r;
            if (sb == 0) r = 0;
            else if (sa == 32'sh8000_0000 && sb == -1) r = sa;
            else r = sa / sb;
            return {32'h0, r};
        end else begin
            longint sa = $signed(a);
            longint sb = $signed(b);
            longint r;
            if (sb == 0) r = 0;
            else if (sa == 64'sh8000_0000_0000_0000 && sb == -1) r = sa;
            else r = sa / sb;
            return r;
        end
    endfunction

    // One operation; disturb changes inputs and pulses start while busy (R9)
    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic w, input bit disturb);
        logic [63:0] exp;
        bit          zero;
        int          lat;
        int          n;
        exp  = ref_div(a, b, w);
        zero = w ? (b == 0) : (b[31:0] == 0);
        lat  = zero ? 0 : (w ? 65 : 33);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; wide = w;
        @(negedge clk);
        start = 1'b0;
        if (zero) chk("R6", "busy after zero-divisor start", {63'b0, busy}, 64'd0);
        else      chk("R2", "busy after accepted start", {63'b0, busy}, 64'd1);
        if (disturb) begin
            dividend = ~a; divisor = b + 64'd3; wide = ~w;
        end
        n = 0;
        while (!done && n < 100) begin
            start = (disturb && n == 5);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(disturb ? "R9" : "R8", "latency", 64'(n), 64'(lat));
        chk(req, "quotient", quotient, exp);
        @(negedge clk);
        chk("R8", "done single pulse", {63'b0, done}, 64'd0);
        chk("R10", "quotient held", quotient, exp);
    endtask

    function automatic logic [63:0] pick_operand();
        unique case ($urandom % 5)
            0: return {$urandom, $urandom};
            1: return 64'($signed(32'($urandom % 201) - 100));
            2: return 64'h8000_0000_0000_0000 >> ($urandom % 64);
            3: return {$urandom, 32'h8000_0000 | 32'($urandom % 4)};
            default: return 64'($signed($urandom)) >>> ($urandom % 31);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", {63'b0, busy}, 64'd0);
        chk("R1", "done after reset", {63'b0, done}, 64'd0);
        chk("R1", "quotient after reset", quotient, 64'd0);

        // Truncation toward zero
        run_op("R3", 64'($signed(-7)), 64'd2, 1'b0, 1'b0);
        chk("R3", "-7/2 narrow", quotient, 64'h0000_0000_FFFF_FFFD);
        run_op("R3", 64'd7, 64'($signed(-2)), 1'b0, 1'b0);
        run_op("R3", 64'($signed(-7)), 64'($signed(-2)), 1'b1, 1'b0);
        run_op("R3", 64'($signed(-7)), 64'd2, 1'b1, 1'b0);
        chk("R3", "-7/2 wide", quotient, 64'hFFFF_FFFF_FFFF_FFFD);
        run_op("R3", 64'd1, 64'd5, 1'b1, 1'b0);

        // Narrow mode ignores upper operand bits
        run_op("R4", 64'hDEAD_BEEF_FFFF_FFF9, 64'h1234_5678_0000_0002, 1'b0, 1'b0);
        chk("R4", "narrow with dirty upper bits", quotient, 64'h0000_0000_FFFF_FFFD);

        // Full width
        run_op("R5", 64'h7FFF_FFFF_FFFF_FFFF, 64'd3, 1'b1, 1'b0);
        run_op("R5", 64'h8000_0000_0000_0001, 64'h0000_0001_0000_0000, 1'b1, 1'b0);

        // Zero divisor
        run_op("R6", 64'd12345, 64'd0, 1'b1, 1'b0);
        run_op("R6", 64'($signed(-9)), 64'hABCD_0000_0000_0000, 1'b0, 1'b0);
        chk("R6", "zero low divisor narrow", quotient, 64'd0);

        // Most-negative over -1 wraps
        run_op("R7", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        chk("R7", "narrow min/-1", quotient, 64'h0000_0000_8000_0000);
        run_op("R7", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        chk("R7", "wide min/-1", quotient, 64'h8000_0000_0000_0000);

        // Input changes and start while busy
        run_op("R9", 64'd1000, 64'($signed(-7)), 1'b0, 1'b1);
        run_op("R9", 64'($signed(-123456789)), 64'd1000, 1'b1, 1'b1);

        // Hold across idle cycles with changing inputs
        begin
            logic [63:0] held;
            held = quotient;
            for (int k = 0; k < 10; k++) begin
                dividend = {$urandom, $urandom}; divisor = {$urandom, $urandom};
                @(negedge clk);
            end
            chk("R10", "quotient held while idle", quotient, held);
        end

        // Constrained random mix
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a, b;
            logic        w;
            a = pick_operand();
            b = pick_operand();
            if ($urandom % 16 == 0) b = '0;
            w = 1'($urandom % 2);
            run_op(w ? "R5" : "R4", a, b, w, ($urandom % 4) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule